// File: doc/BRIEF.md
# Descriptor Ring Copy Sequencer

The block walks a circular ring of 16-byte copy descriptors kept in memory. For each entry it reads the descriptor through a word-wide request/response memory port and checks the hardware-ownership flag. It then copies the requested byte count from the source pointer to the destination pointer. The copy is split into bursts: each burst is read into a local buffer and then written out. Finally the engine writes a status word over the first descriptor word, which clears ownership and hands the entry back to software.

Processing starts on a one-cycle `start` pulse. It continues entry by entry, wrapping from the last entry to the ring base, until the engine meets an entry it does not own. The engine then goes idle and keeps its position. A later `start` resumes at that same entry. Ring placement, entry count and burst limit are plain configuration inputs and are held steady while the engine is busy.

Descriptor format (byte offsets, little-endian words):
- +0: control word. Bit 31 is the owned flag, bit 30 requests a done event, and bits 26:0 hold the size in bytes.
- +4: destination address bits 47:32 in bits 15:0, and source address bits 47:32 in bits 31:16.
- +8: destination address bits 31:0.
- +12: source address bits 31:0.

Top module: `dring_sequencer`

## Requirements
- R1: After reset `busy`, `mem_req`, `ev_done` and `ev_error` are 0, and `next_addr` equals the 48-bit ring base (`{ring_base_hi[15:0], ring_base_lo}`).
- R2: An entry is fetched with four 4-byte reads at entry offsets +0, +4, +8 and +12, in that order. The entry address is base + index*16.
- R3: If bit 31 of the control word is 0, the engine stops. It makes no further request, drops `busy`, leaves the entry unwritten, and `next_addr` stays on that entry.
- R4: A valid entry copies `size` bytes from the 48-bit source to the 48-bit destination. Bytes beyond `size` at the destination are untouched.
- R5: Data moves in bursts: up to the burst limit is read, then those bytes are written. `burst_code` selects the limit: 0=64, 1=128, 2=256, 3=512, 4=1024, 5=2048, 7=4, and 6=64 bytes. Each beat carries 1 to 4 bytes.
- R6: On completion the control word is rewritten with bit 31 = 0, bit 30 = 1 on success, bit 27 = 0, and bits 26:0 holding the bytes not transferred. For a full copy the word is 0x4000_0000.
- R7: A read error response ends the entry. The write-back has bit 29 set, bit 30 clear, and the remainder is size minus bytes already written. `ev_error` pulses.
- R8: A write error response ends the entry. The write-back has bit 28 set, bit 30 clear, and the same remainder rule applies. `ev_error` pulses.
- R9: `ev_done` pulses for exactly one cycle after a write-back, and only if bit 30 of the fetched control word was set.
- R10: After the entry at index `ring_count-1` the index wraps to 0, so `next_addr` returns to the base.
- R11: A `start` after a stop resumes fetching at the entry where the engine stopped.
- R12: A valid entry of size 0 issues no data requests and is written back as 0x4000_0000.
- R13: A memory request holds its address, direction, byte count and write data until `mem_ack`.
- R14: An error response while fetching an entry pulses `ev_error` and stops the engine without writing that entry back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or resume processing when idle |
| ring_base_lo | input | 32 | Ring base address bits 31:0 |
| ring_base_hi | input | 32 | Ring base address upper word (bits 15:0 used) |
| ring_count | input | IDX_W | Number of ring entries (at least 1) |
| burst_code | input | 3 | Burst length selector |
| busy | output | 1 | Engine is processing |
| next_addr | output | 48 | Address of the entry to be fetched next |
| ev_done | output | 1 | One-cycle entry-complete event |
| ev_error | output | 1 | One-cycle error event |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 48 | Byte address |
| mem_nbytes | output | 3 | Bytes in this beat (1 to 4) |
| mem_wdata | output | 32 | Write data, lowest byte at `mem_addr` |
| mem_ack | input | 1 | Request accepted and completed this cycle |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
A corrupted copy offset or done count shows up at the next data beat as a wrong `mem_addr`. It also shows up at write-back as a wrong remainder field, so a single entry reveals it. A wrong ring index appears on the very next fetch address and on `next_addr` once the engine idles. The wrap and resume tests catch such an error within one entry. A failure-flag or ownership error is visible in the write-back word a few cycles after the faulting response. The bench reads that word back from its memory model.

// File: rtl/dring_sequencer.sv
module dring_sequencer #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      ring_base_lo,
  input  logic [31:0]      ring_base_hi,
  input  logic [IDX_W-1:0] ring_count,
  input  logic [2:0]       burst_code,
  output logic             busy,
  output logic [47:0]      next_addr,
  output logic             ev_done,
  output logic             ev_error,
  output logic             mem_req,
  output logic             mem_we,
  output logic [47:0]      mem_addr,
  output logic [2:0]       mem_nbytes,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [31:0]      mem_rdata
);
  localparam int SZ_W  = 27;
  localparam int MAXB  = 2048;
  localparam int OFF_W = $clog2(MAXB) + 1;
  localparam int BUF_N = MAXB / 4;
  localparam int BUF_W = $clog2(BUF_N);

  typedef enum logic [3:0] {S_IDLE, S_F0, S_F1, S_F2, S_F3, S_NXT, S_RD, S_WR, S_WB} st_t;
  st_t st;

  logic [IDX_W-1:0] idx;
  logic [SZ_W-1:0]  size_r, done_r;
  logic             intr_r, rdf, wrf;
  logic [47:0]      src, dst;
  logic [OFF_W-1:0] chunk, off;
  logic [31:0]      dbuf [BUF_N];

  function automatic logic [OFF_W-1:0] burst_len(input logic [2:0] c);
    case (c)
      3'd1: burst_len = OFF_W'(128);
      3'd2: burst_len = OFF_W'(256);
      3'd3: burst_len = OFF_W'(512);
      3'd4: burst_len = OFF_W'(1024);
      3'd5: burst_len = OFF_W'(2048);
      3'd7: burst_len = OFF_W'(4);
      default: burst_len = OFF_W'(64);
    endcase
  endfunction

  logic [SZ_W-1:0]  left;
  logic [OFF_W-1:0] blen, rem;
  logic [2:0]       nb;
  logic [IDX_W:0]   idx_inc;
  logic [31:0]      wb_word;

  assign left      = size_r - done_r;
  assign blen      = burst_len(burst_code);
  assign rem       = chunk - off;
  assign nb        = (rem >= OFF_W'(4)) ? 3'd4 : rem[2:0];
  assign idx_inc   = {1'b0, idx} + 1'b1;
  assign next_addr = {ring_base_hi[15:0], ring_base_lo} + {idx, 4'b0000};
  assign busy      = (st != S_IDLE);
  assign wb_word   = {1'b0, ~(rdf | wrf), rdf, wrf, 1'b0, left};

  assign mem_req    = busy && (st != S_NXT);
  assign mem_we     = (st == S_WR) || (st == S_WB);
  assign mem_nbytes = ((st == S_RD) || (st == S_WR)) ? nb : 3'd4;
  assign mem_wdata  = (st == S_WB) ? wb_word : dbuf[off[BUF_W+1:2]];

  always_comb begin
    case (st)
      S_F1:    mem_addr = next_addr + 48'd4;
      S_F2:    mem_addr = next_addr + 48'd8;
      S_F3:    mem_addr = next_addr + 48'd12;
      S_RD:    mem_addr = src + 48'(done_r) + 48'(off);
      S_WR:    mem_addr = dst + 48'(done_r);
      default: mem_addr = next_addr;
    endcase
  end

  always_ff @(posedge clk)
    if (st == S_RD && mem_ack && !mem_err) dbuf[off[BUF_W+1:2]] <= mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; size_r <= '0; done_r <= '0; intr_r <= 1'b0;
      rdf <= 1'b0; wrf <= 1'b0; src <= '0; dst <= '0; chunk <= '0; off <= '0;
      ev_done <= 1'b0; ev_error <= 1'b0;
    end else begin
      ev_done  <= 1'b0;
      ev_error <= 1'b0;
      case (st)
        S_IDLE: if (start) st <= S_F0;
        S_F0: if (mem_ack) begin
          if (mem_err) begin ev_error <= 1'b1; st <= S_IDLE; end
          else if (!mem_rdata[31]) st <= S_IDLE;
          else begin
            size_r <= mem_rdata[SZ_W-1:0]; intr_r <= mem_rdata[30];
            done_r <= '0; rdf <= 1'b0; wrf <= 1'b0; st <= S_F1;
          end
        end
        S_F1: if (mem_ack) begin
          if (mem_err) begin ev_error <= 1'b1; st <= S_IDLE; end
          else begin dst[47:32] <= mem_rdata[15:0]; src[47:32] <= mem_rdata[31:16]; st <= S_F2; end
        end
        S_F2: if (mem_ack) begin
          if (mem_err) begin ev_error <= 1'b1; st <= S_IDLE; end
          else begin dst[31:0] <= mem_rdata; st <= S_F3; end
        end
        S_F3: if (mem_ack) begin
          if (mem_err) begin ev_error <= 1'b1; st <= S_IDLE; end
          else begin src[31:0] <= mem_rdata; st <= S_NXT; end
        end
        S_NXT: begin
          off <= '0;
          if (left == '0) st <= S_WB;
          else begin
            chunk <= (left > SZ_W'(blen)) ? blen : left[OFF_W-1:0];
            st <= S_RD;
          end
        end
        S_RD: if (mem_ack) begin
          if (mem_err) begin rdf <= 1'b1; st <= S_WB; end
          else if (off + OFF_W'(nb) == chunk) begin off <= '0; st <= S_WR; end
          else off <= off + OFF_W'(nb);
        end
        S_WR: if (mem_ack) begin
          if (mem_err) begin wrf <= 1'b1; st <= S_WB; end
          else begin
            done_r <= done_r + SZ_W'(nb);
            if (off + OFF_W'(nb) == chunk) st <= S_NXT;
            else off <= off + OFF_W'(nb);
          end
        end
        S_WB: if (mem_ack) begin
          if (mem_err) begin ev_error <= 1'b1; st <= S_IDLE; end
          else begin
            ev_done  <= intr_r;
            ev_error <= rdf | wrf;
            idx <= (idx_inc >= {1'b0, ring_count}) ? '0 : idx_inc[IDX_W-1:0];
            st <= S_F0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_nbytes)); // R13
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !ev_done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R3
  AST_BEAT_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_nbytes != 3'd0) && (mem_nbytes <= 3'd4)); // R5
  AST_WB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB) && mem_req |-> !mem_wdata[31] && (mem_wdata[30] != (mem_wdata[29] | mem_wdata[28]))); // R6
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ring_count) && (ring_count != '0) |-> idx < ring_count); // R10
endmodule

// File: tb/dring_sequencer_bench.sv
module dring_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 12;
  localparam logic [47:0] BASE = 48'h0012_0000_1000;
  localparam logic [47:0] SRC  = 48'h0003_0000_0000;
  localparam logic [47:0] DST  = 48'h0005_0000_0002;

  logic clk = 0, rst_n = 0, start = 0;
  logic [IDX_W-1:0] ring_count = 12'd16;
  logic [2:0] burst_code = 3'd0;
  logic busy, ev_done, ev_error, mem_req, mem_we;
  logic [47:0] next_addr, mem_addr;
  logic [2:0] mem_nbytes;
  logic [31:0] mem_wdata;
  logic mem_ack = 0, mem_err = 0;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dring_sequencer #(.IDX_W(IDX_W)) u_dring_sequencer (
    .clk, .rst_n, .start, .ring_base_lo(BASE[31:0]), .ring_base_hi({16'h0, BASE[47:32]}),
    .ring_count, .burst_code, .busy, .next_addr, .ev_done, .ev_error,
    .mem_req, .mem_we, .mem_addr, .mem_nbytes, .mem_wdata, .mem_ack, .mem_err, .mem_rdata);

  int errors = 0, checks = 0;
  logic [7:0] mem [logic [47:0]];
  int lat = 0, cnt = 0;
  int fault_kind = 0;
  logic [47:0] fault_addr = '0;
  int done_cnt, err_cnt, wide_cnt, data_reqs, run, max_run, ntx;
  logic [47:0] tx_log [8];
  logic prev_done = 0;
  int cycles = 0;

  function automatic logic [7:0] rd8(logic [47:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [31:0] rd32(logic [47:0] a);
    return {rd8(a+3), rd8(a+2), rd8(a+1), rd8(a)};
  endfunction
  task automatic put32(logic [47:0] a, logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a+i] = v[8*i +: 8];
  endtask
  function automatic bit in_ring(logic [47:0] a);
    return a >= BASE && a < BASE + 48'(ring_count) * 16;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; cnt = 0;
    end else if (mem_ack) begin
      mem_ack <= 0;
    end else if (mem_req) begin
      if (cnt < lat) cnt++;
      else begin
        cnt = 0;
        if (ntx < 8) tx_log[ntx] = mem_addr;
        ntx++;
        if (!in_ring(mem_addr)) begin
          data_reqs++;
          if (mem_we) begin if (run > max_run) max_run = run; run = 0; end
          else run += int'(mem_nbytes);
        end
        if (mem_addr == fault_addr && ((fault_kind == 1 && !mem_we) || (fault_kind == 2 && mem_we))) begin
          mem_err <= 1; mem_rdata <= '0;
        end else begin
          mem_err <= 0;
          if (mem_we) begin
            for (int i = 0; i < int'(mem_nbytes); i++) mem[mem_addr+i] = mem_wdata[8*i +: 8];
            mem_rdata <= '0;
          end else begin
            logic [31:0] d;
            d = '0;
            for (int i = 0; i < int'(mem_nbytes); i++) d[8*i +: 8] = rd8(mem_addr+i);
            mem_rdata <= d;
          end
        end
        mem_ack <= 1;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (ev_done) done_cnt++;
    if (ev_error) err_cnt++;
    if (ev_done && prev_done) wide_cnt++;
    prev_done = ev_done;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(int latency, logic [IDX_W-1:0] count, logic [2:0] code);
    rst_n = 0; lat = latency; ring_count = count; burst_code = code;
    fault_kind = 0; mem.delete();
    done_cnt = 0; err_cnt = 0; wide_cnt = 0; data_reqs = 0; run = 0; max_run = 0; ntx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic put_desc(int i, int size, bit intr, bit valid, logic [47:0] d, logic [47:0] s);
    logic [47:0] a;
    a = BASE + 48'(i) * 16;
    put32(a, {valid, intr, 3'b000, 27'(size)});
    put32(a + 4, {s[47:32], d[47:32]});
    put32(a + 8, d[31:0]);
    put32(a + 12, s[31:0]);
  endtask

  task automatic fill_src(int n);
    for (int i = 0; i < n; i++) mem[SRC + 48'(i)] = 8'(i * 7 + 3);
  endtask

  task automatic run_engine();
    start = 1; @(negedge clk); start = 0;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(0, 12'd16, 3'd0);
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 events", {ev_done, ev_error}, 0);
    chk("R1 next_addr", next_addr, BASE);
  endtask

  task automatic t_basic();
    bit same;
    do_reset(1, 12'd16, 3'd0);
    fill_src(100);
    put_desc(0, 100, 1, 1, DST, SRC);
    put_desc(1, 40, 1, 0, DST, SRC);
    run_engine();
    chk("R2 fetch +0", tx_log[0], BASE);
    chk("R2 fetch +4", tx_log[1], BASE + 4);
    chk("R2 fetch +8", tx_log[2], BASE + 8);
    chk("R2 fetch +12", tx_log[3], BASE + 12);
    same = 1;
    for (int i = 0; i < 100; i++) if (rd8(DST + 48'(i)) !== rd8(SRC + 48'(i))) same = 0;
    chk("R4 copied bytes", same, 1);
    chk("R4 byte past end", rd8(DST + 100), 0);
    chk("R6 writeback word", rd32(BASE), 32'h4000_0000);
    chk("R5 burst 64", max_run, 64);
    chk("R9 done count", done_cnt, 1);
    chk("R9 done width", wide_cnt, 0);
    chk("R3 stop next_addr", next_addr, BASE + 16);
    chk("R3 entry untouched", rd32(BASE + 16), {1'b0, 1'b1, 30'd40});
    chk("R3 idle", busy, 0);
  endtask

  task automatic t_burst(logic [2:0] code, int size, int exp_run);
    do_reset(0, 12'd16, code);
    fill_src(size);
    put_desc(0, size, 0, 1, DST, SRC);
    run_engine();
    chk($sformatf("R5 burst code %0d", code), max_run, exp_run);
    chk("R6 burst writeback", rd32(BASE), 32'h4000_0000);
    chk("R9 no done without request", done_cnt, 0);
  endtask

  task automatic t_rdfail();
    do_reset(2, 12'd16, 3'd0);
    fill_src(200);
    put_desc(0, 200, 1, 1, DST, SRC);
    fault_kind = 1; fault_addr = SRC + 132;
    run_engine();
    chk("R7 writeback", rd32(BASE), 32'h2000_0048);
    chk("R7 error event", err_cnt, 1);
    chk("R7 no write past failure", rd8(DST + 128), 0);
    chk("R7 earlier bytes", rd8(DST + 127), rd8(SRC + 127));
  endtask

  task automatic t_wrfail();
    do_reset(1, 12'd16, 3'd0);
    fill_src(200);
    put_desc(0, 200, 0, 1, DST, SRC);
    fault_kind = 2; fault_addr = DST + 68;
    run_engine();
    chk("R8 writeback", rd32(BASE), 32'h1000_0084);
    chk("R8 error event", err_cnt, 1);
  endtask

  task automatic t_zero();
    do_reset(0, 12'd16, 3'd0);
    put_desc(0, 0, 1, 1, DST, SRC);
    run_engine();
    chk("R12 writeback", rd32(BASE), 32'h4000_0000);
    chk("R12 no data requests", data_reqs, 0);
    chk("R12 done", done_cnt, 1);
  endtask

  task automatic t_wrap();
    do_reset(0, 12'd3, 3'd0);
    fill_src(8);
    for (int i = 0; i < 3; i++) put_desc(i, 8, 0, 1, DST, SRC);
    run_engine();
    for (int i = 0; i < 3; i++) chk($sformatf("R10 entry %0d written back", i), rd32(BASE + 48'(i) * 16), 32'h4000_0000);
    chk("R10 wrapped next_addr", next_addr, BASE);
    put_desc(0, 4, 1, 1, DST, SRC);
    done_cnt = 0;
    run_engine();
    chk("R11 resumed entry done", rd32(BASE), 32'h4000_0000);
    chk("R11 resume next_addr", next_addr, BASE + 16);
    chk("R11 done", done_cnt, 1);
  endtask

  task automatic t_fetchfail();
    do_reset(1, 12'd16, 3'd0);
    put_desc(0, 16, 1, 1, DST, SRC);
    fault_kind = 1; fault_addr = BASE + 8;
    run_engine();
    chk("R14 error event", err_cnt, 1);
    chk("R14 not written back", rd32(BASE), {1'b1, 1'b1, 30'd16});
    chk("R14 idle", busy, 0);
    chk("R14 next_addr kept", next_addr, BASE);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_burst(3'd7, 10, 4);
    t_burst(3'd5, 3000, 2048);
    t_burst(3'd6, 100, 64);
    t_rdfail();
    t_wrfail();
    t_zero();
    t_wrap();
    t_fetchfail();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule